// File: doc/BRIEF.md
# Shutdown, Warm-Reset and Lockout Controller

This block owns the sleep and soft-reset controls of a temperature-monitoring device. It holds a configuration register, which carries a sleep bit and a self-clearing warm-reset bit, and a sticky lock register. In the lock register one bit forbids sleep and another forbids warm resets. From register writes it derives the shutdown state and a set of single-cycle action pulses. The neighbouring logic uses these pulses to clear the event status, purge the fault queues, release the interrupt line, abort an in-flight conversion and reload the limit registers with their defaults.

Lock bits can only be set. Once set, a bit stays set until a warm or power-on reset. Setting either lock bit while the device sleeps wakes it at once. A warm reset returns every register to its power-on value, including the lock bits. A lock write and a configuration write can arrive in the same cycle. In that case the lock is applied first, so a lock set in that cycle already blocks the configuration write.

Top module: `shdn_lock_ctrl`

## Requirements
- R1: After the synchronous power-on reset, shutdown is 0, the configuration reads 0x0C, the lock register reads 0x00 and all five action pulses are 0.
- R2: A configuration write with bit 0 (sleep) at 1, while awake and with lock bit 3 clear, raises shutdown in the cycle after the write. In that same cycle it gives one-cycle pulses on int_deassert, status_clr and fq_purge, and none on conv_abort or lim_restore. The other written bits are stored.
- R3: While lock bit 3 is set, a configuration write cannot set bit 0. The remaining bits of that write are still stored.
- R4: A lock write with bit 3 or bit 4 at 1 while shut down clears shutdown in the next cycle and gives no action pulse.
- R5: A configuration write with bit 7 (warm reset) at 1, while lock bit 4 is and stays clear, gives a one-cycle pulse on all five action outputs in the next cycle. In that cycle the configuration reads 0x0C and the lock register reads 0x00.
- R6: While lock bit 4 is set, bit 7 of a configuration write has no effect. The other bits of the write are stored as with bit 7 at 0.
- R7: Lock bits 4..0 are sticky: writing 0 never clears them. Lock bits 7..5 always read 0.
- R8: Bit 7 of the configuration always reads back as 0.
- R9: When one cycle carries a lock write and a configuration write, the lock write applies first. A lock bit 4 set in that cycle blocks the warm reset. A lock bit 3 set in that cycle blocks entry to shutdown.
- R10: A configuration write with bit 0 at 0 while shut down clears shutdown in the next cycle, with no action pulse.
- R11: A warm reset issued while shut down also clears shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| lock_wr | input | 1 | Lock register write strobe |
| lock_wdata | input | 8 | Lock write data |
| cfg_rdata | output | 8 | Configuration read value |
| lock_rdata | output | 8 | Lock read value |
| shutdown | output | 1 | Device is asleep |
| int_deassert | output | 1 | Pulse: release interrupt line |
| status_clr | output | 1 | Pulse: clear event status |
| fq_purge | output | 1 | Pulse: purge fault queues |
| conv_abort | output | 1 | Pulse: abort conversion and discard result |
| lim_restore | output | 1 | Pulse: reload limit defaults |

## Verification
The assertions check properties that must hold on every cycle. Every entry into sleep carries the clear, purge and release pulses. Each restore pulse arrives together with the other reset pulses and with zeroed locks. Lock bits never drop except on a warm reset. A set lock bit blocks any later entry into sleep or warm reset. Write ordering can only be shown by the bench scenarios: lock and configuration writes landing in the same cycle, waking through either lock bit, and the sweep over every lock value crossed with sleep state and write pattern.

// File: rtl/shdn_lock_pkg.sv
package shdn_lock_pkg;

  // Action pulses driven to neighbouring logic
  typedef struct packed {
    logic int_deassert;
    logic status_clr;
    logic fq_purge;
    logic conv_abort;
    logic lim_restore;
  } act_t;

  localparam act_t ACT_NONE  = '{default: 1'b0};
  localparam act_t ACT_SLEEP = '{int_deassert: 1'b1, status_clr: 1'b1, fq_purge: 1'b1,
                                 conv_abort: 1'b0, lim_restore: 1'b0};
  localparam act_t ACT_WARM  = '{default: 1'b1};

endpackage

// File: rtl/lock_bank.sv
module lock_bank #(
  parameter int LOCK_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [LOCK_W-1:0] lock_nxt,
  output logic [LOCK_W-1:0] lock_q
);

  // Each bit can only be set by a write; only reset clears it
  for (genvar i = 0; i < LOCK_W; i++) begin : g_bit
    logic set_i;
    assign set_i       = wr & wdata[i];
    assign lock_nxt[i] = lock_q[i] | set_i;

    always_ff @(posedge clk) begin
      if (rst || clr) lock_q[i] <= 1'b0;
      else            lock_q[i] <= lock_nxt[i];
    end
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int              CFG_W       = 8,
  parameter int              SD_BIT      = 0,
  parameter int              RST_BIT     = 7,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h0C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             warm,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             sd_block,
  input  logic             wake,
  output logic [CFG_W-1:0] cfg_q,
  output logic             sd_rise
);

  localparam logic [CFG_W-1:0] CTRL_MASK = (CFG_W'(1) << SD_BIT) | (CFG_W'(1) << RST_BIT);
  localparam logic [CFG_W-1:0] DEF_CLEAN = CFG_DEFAULT & ~CTRL_MASK;

  logic [CFG_W-1:0] cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (wr) begin
      cfg_nxt          = wdata;
      cfg_nxt[RST_BIT] = 1'b0;
      if (sd_block && !cfg_q[SD_BIT]) cfg_nxt[SD_BIT] = 1'b0;
    end
    if (wake) cfg_nxt[SD_BIT] = 1'b0;
  end

  assign sd_rise = cfg_nxt[SD_BIT] & ~cfg_q[SD_BIT] & ~warm;

  always_ff @(posedge clk) begin
    if (rst || warm) cfg_q <= DEF_CLEAN;
    else             cfg_q <= cfg_nxt;
  end

endmodule

// File: rtl/action_pulse.sv
module action_pulse
  import shdn_lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic warm,
  input  logic sd_rise,
  output act_t act_q
);

  act_t act_d;

  always_comb begin
    if (warm)         act_d = ACT_WARM;
    else if (sd_rise) act_d = ACT_SLEEP;
    else              act_d = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= ACT_NONE;
    else     act_q <= act_d;
  end

endmodule

// File: rtl/shdn_lock_ctrl.sv
module shdn_lock_ctrl
  import shdn_lock_pkg::*;
#(
  parameter int               CFG_W       = 8,
  parameter int               LOCK_W      = 5,
  parameter int               SD_BIT      = 0,
  parameter int               RST_BIT     = 7,
  parameter int               SDLK_BIT    = 3,
  parameter int               RSTLK_BIT   = 4,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h0C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lock_wr,
  input  logic [CFG_W-1:0] lock_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [CFG_W-1:0] lock_rdata,
  output logic             shutdown,
  output logic             int_deassert,
  output logic             status_clr,
  output logic             fq_purge,
  output logic             conv_abort,
  output logic             lim_restore
);

  logic [LOCK_W-1:0] lock_nxt;
  logic [LOCK_W-1:0] lock_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              warm;
  logic              wake;
  logic              sd_rise;
  act_t              act_q;

  // Lock takes effect before the configuration write of the same cycle
  assign warm = cfg_wr & cfg_wdata[RST_BIT] & ~lock_nxt[RSTLK_BIT];
  assign wake = cfg_q[SD_BIT] & lock_wr & (lock_wdata[SDLK_BIT] | lock_wdata[RSTLK_BIT]);

  lock_bank #(.LOCK_W(LOCK_W), .DATA_W(CFG_W)) lock_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (warm),
    .wr       (lock_wr),
    .wdata    (lock_wdata),
    .lock_nxt (lock_nxt),
    .lock_q   (lock_q)
  );

  cfg_bank #(
    .CFG_W(CFG_W), .SD_BIT(SD_BIT), .RST_BIT(RST_BIT), .CFG_DEFAULT(CFG_DEFAULT)
  ) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .warm     (warm),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .sd_block (lock_nxt[SDLK_BIT]),
    .wake     (wake),
    .cfg_q    (cfg_q),
    .sd_rise  (sd_rise)
  );

  action_pulse act_i (
    .clk     (clk),
    .rst     (rst),
    .warm    (warm),
    .sd_rise (sd_rise),
    .act_q   (act_q)
  );

  assign cfg_rdata    = cfg_q;
  assign lock_rdata   = CFG_W'(lock_q);
  assign shutdown     = cfg_q[SD_BIT];
  assign int_deassert = act_q.int_deassert;
  assign status_clr   = act_q.status_clr;
  assign fq_purge     = act_q.fq_purge;
  assign conv_abort   = act_q.conv_abort;
  assign lim_restore  = act_q.lim_restore;

endmodule

// File: rtl/shdn_lock_chk.sv
module shdn_lock_chk #(
  parameter int               CFG_W       = 8,
  parameter int               SDLK_BIT    = 3,
  parameter int               RSTLK_BIT   = 4,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h0C
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic [CFG_W-1:0] lock_rdata,
  input logic             shutdown,
  input logic             int_deassert,
  input logic             status_clr,
  input logic             fq_purge,
  input logic             conv_abort,
  input logic             lim_restore
);

  // R2: entering sleep always carries the sleep pulses only
  a_r2_sleep_pulses: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> (int_deassert && status_clr && fq_purge && !conv_abort && !lim_restore));

  // R5: restore pulse comes with the full reset action set and cleared state
  a_r5_warm_bundle: assert property (@(posedge clk) disable iff (rst)
    lim_restore |-> (conv_abort && int_deassert && fq_purge && status_clr && !shutdown
                     && lock_rdata == '0 && cfg_rdata == CFG_DEFAULT));

  // R3: a held sleep lock blocks any later entry into sleep
  a_r3_sleep_locked: assert property (@(posedge clk) disable iff (rst)
    lock_rdata[SDLK_BIT] |=> !$rose(shutdown));

  // R6: a held reset lock blocks any later warm reset
  a_r6_reset_locked: assert property (@(posedge clk) disable iff (rst)
    lock_rdata[RSTLK_BIT] |=> !lim_restore);

  // R7: lock bits fall only on a warm reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    !lim_restore |-> (($past(lock_rdata) & ~lock_rdata) == '0));

  // R4 / R10: leaving sleep without a warm reset purges nothing
  a_r4_quiet_wake: assert property (@(posedge clk) disable iff (rst)
    $fell(shutdown) |-> (lim_restore || (!fq_purge && !status_clr && !int_deassert)));

endmodule

bind shdn_lock_ctrl shdn_lock_chk #(
  .CFG_W(CFG_W), .SDLK_BIT(SDLK_BIT), .RSTLK_BIT(RSTLK_BIT), .CFG_DEFAULT(CFG_DEFAULT)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_rdata    (cfg_rdata),
  .lock_rdata   (lock_rdata),
  .shutdown     (shutdown),
  .int_deassert (int_deassert),
  .status_clr   (status_clr),
  .fq_purge     (fq_purge),
  .conv_abort   (conv_abort),
  .lim_restore  (lim_restore)
);

// File: tb/shdn_lock_ctrl_tb.sv
module shdn_lock_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       lock_wr = 1'b0;
  logic [7:0] lock_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] lock_rdata;
  logic       shutdown;
  logic       int_deassert, status_clr, fq_purge, conv_abort, lim_restore;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  // bench model state
  logic [7:0] m_cfg  = 8'h0C;
  logic [7:0] m_lock = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shdn_lock_ctrl dut_i (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lock_wr(lock_wr), .lock_wdata(lock_wdata),
    .cfg_rdata(cfg_rdata), .lock_rdata(lock_rdata), .shutdown(shutdown),
    .int_deassert(int_deassert), .status_clr(status_clr), .fq_purge(fq_purge),
    .conv_abort(conv_abort), .lim_restore(lim_restore)
  );

  // pulse order: int_deassert, status_clr, fq_purge, conv_abort, lim_restore
  task automatic compare(input string tag, input logic [4:0] e_p);
    logic [21:0] act, exp;
    act = {shutdown, cfg_rdata, lock_rdata, int_deassert, status_clr, fq_purge, conv_abort, lim_restore};
    exp = {m_cfg[0], m_cfg, m_lock, e_p};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit cw, input logic [7:0] cd,
                      input bit lw, input logic [7:0] ld);
    logic [7:0] nl, nc;
    logic       wake, rq;
    logic [4:0] e_p;
    nl   = m_lock | (lw ? (ld & 8'h1F) : 8'h00);
    wake = m_cfg[0] && lw && (ld[3] || ld[4]);
    rq   = cw && cd[7] && !nl[4];
    e_p  = 5'b00000;
    if (rq) begin
      m_cfg  = 8'h0C;
      m_lock = 8'h00;
      e_p    = 5'b11111;
    end else begin
      nc = m_cfg;
      if (cw) begin
        nc = cd & 8'h7F;
        if (nl[3] && !m_cfg[0]) nc[0] = 1'b0;
      end
      if (wake) nc[0] = 1'b0;
      if (nc[0] && !m_cfg[0]) e_p = 5'b11100;
      m_cfg  = nc;
      m_lock = nl;
    end
    @(negedge clk);
    cfg_wr = cw; cfg_wdata = cd; lock_wr = lw; lock_wdata = ld;
    @(negedge clk);
    cfg_wr = 1'b0; lock_wr = 1'b0;
    compare(tag, e_p);
  endtask

  task automatic por();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cfg = 8'h0C; m_lock = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state", 5'b0);

    // R2 enter sleep, other bits stored; R8 bit 7 reads 0
    step("R2 sleep entry", 1, 8'h31, 0, 8'h00);
    step("R2 pulse ends", 0, 8'h00, 0, 8'h00);
    // R10 wake by clearing sleep bit
    step("R10 wake by config", 1, 8'h30, 0, 8'h00);
    // R7 sticky locks, upper bits ignored
    step("R7 set lock bit1", 0, 8'h00, 1, 8'h02);
    step("R7 write zero keeps", 0, 8'h00, 1, 8'h00);
    step("R7 upper bits ignored", 0, 8'h00, 1, 8'hE0);
    // R3 sleep lock
    step("R3 set sleep lock", 0, 8'h00, 1, 8'h08);
    step("R3 sleep blocked", 1, 8'h45, 0, 8'h00);
    // R5 warm reset clears locks, R8
    step("R5 warm reset", 1, 8'hA1, 0, 8'h00);
    step("R5 pulse ends", 0, 8'h00, 0, 8'h00);
    // R4 wake via lock bit 4, then R6 reset ignored
    step("R4 sleep again", 1, 8'h01, 0, 8'h00);
    step("R4 wake via reset lock", 0, 8'h00, 1, 8'h10);
    step("R6 reset ignored R8", 1, 8'hC2, 0, 8'h00);
    // R11 warm reset from sleep
    por();
    step("R11 sleep", 1, 8'h01, 0, 8'h00);
    step("R11 warm from sleep", 1, 8'h80, 0, 8'h00);
    // R9 same-cycle ordering
    step("R9 lock4 and reset", 1, 8'h80, 1, 8'h10);
    por();
    step("R9 lock3 and sleep", 1, 8'h01, 1, 8'h08);
    por();
    step("R4 sleep", 1, 8'h01, 0, 8'h00);
    step("R4 wake via sleep lock", 0, 8'h00, 1, 8'h08);

    // sweep: every lock value x sleep state x write pattern
    for (int lk = 0; lk < 32; lk++) begin
      for (int sd = 0; sd < 2; sd++) begin
        for (int pat = 0; pat < 8; pat++) begin
          logic [7:0] cd;
          logic [7:0] ld;
          por();
          if (sd != 0) step("R2 sweep sleep", 1, 8'h01, 0, 8'h00);
          step("R4/R7 sweep lock", 0, 8'h00, 1, 8'(lk));
          cd = {pat[2], 6'b010101, pat[0]};
          ld = {3'b000, pat[1], pat[1] ^ pat[2], 3'b000};
          step("R3/R5/R6/R9 sweep write", 1, cd, pat[1], ld);
          step("R5/R7 sweep idle", 0, 8'h00, 0, 8'h00);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule